// File: doc/BRIEF.md
# Bit-Field Extract and Deposit Unit

This datapath block pulls a bit field out of a 32-bit word or places a field into one, and presents the answer on a registered output one clock after the request. It supports two extract forms and one descriptor-driven extract. An unsigned extract right-justifies the field and clears the bits above it. A signed extract fills the bits above the field with copies of the field's top bit. The descriptor-driven extract takes both bounds from a packed word.

It also supports three deposit forms. A merge deposit writes the low bits of a source word into a target word at a chosen position. A zeroing deposit writes those bits into an all-zero word. An immediate deposit writes a small sign-extended constant into the target.

For the extract and deposit forms, the field position comes either from a shift-amount operand or from an immediate position operand. A select bit chooses between the two. The field length is a separate operand. An issuing pipeline stage drives one request per cycle, qualified by a valid bit.

Top module: `bf_unit`

## Requirements
- R1: With `op` = 0 (unsigned extract), the result holds `opa` bits starting at position P in its low bits, for the effective length, and every higher bit is 0. P is `sar` when `use_sar` is 1 and `imm_pos` when it is 0. Bit 0 is the least significant bit.
- R2: With `op` = 1 (signed extract), the result equals the unsigned extract, except that all bits above the field copy the field's most significant bit.
- R3: The effective extract length is the smaller of `fld_len` and 32−P. For every deposit, field bits that would land above bit 31 are dropped.
- R4: With `op` = 2 (merge deposit), target bits P up to P+`fld_len`−1 of `opb` are replaced by the low `fld_len` bits of `opa`, and all other `opb` bits pass unchanged.
- R5: With `op` = 3 (zeroing deposit), the result carries the low `fld_len` bits of `opa` at P, and every other bit is 0.
- R6: With `op` = 4 (immediate deposit), the 5-bit `imm_val` is sign-extended to 32 bits and merged into `opb` at P, as in R4.
- R7: With `op` = 5 (descriptor extract), `opb[11:6]` is the high index H and `opb[5:0]` is the low index L. H above 31 counts as 31. The result is `opa` bits L..H shifted right by L, with zero fill.
- R8: In descriptor extract, L greater than H, or L greater than 31, gives a zero result.
- R9: A `fld_len` of 0 is an empty field. Extracts then give 0, merge and immediate deposits return `opb` unchanged, and the zeroing deposit gives 0. A `fld_len` above 32 acts as 32.
- R10: The opcodes 6 and 7 produce a zero result with a valid output.
- R11: `res_valid` rises exactly one cycle after a cycle with `in_valid` high and is low after any cycle without it. `res_data` holds its value across cycles without `in_valid`.
- R12: While `rst_n` is low, `res_valid` and `res_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| op | input | 3 | Operation select (see R1–R10 encodings) |
| opa | input | 32 | Source word |
| opb | input | 32 | Target word for deposits, descriptor for descriptor extract |
| use_sar | input | 1 | 1: position from `sar`, 0: from `imm_pos` |
| sar | input | 5 | Shift-amount position |
| imm_pos | input | 5 | Immediate position |
| fld_len | input | 6 | Field length, 0..63 |
| imm_val | input | 5 | Immediate deposit value |
| res_valid | output | 1 | Result qualifier |
| res_data | output | 32 | Registered result |

## Verification
Every request is checked one cycle later. A wrong mask, shift or sign selection therefore shows as a mismatched result word on the very next `res_valid`. The sweeps cover every position and every length from 0 to 33 for each opcode, with random operands, so a fault in one shifter stage or one mask bit is hit by many positions. Descriptor bounds are swept on both sides of the empty and clipped cases. Idle cycles expose any leak of a result or valid when no request is present.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam logic [2:0] OP_EXTU = 3'd0;
  localparam logic [2:0] OP_EXTS = 3'd1;
  localparam logic [2:0] OP_DEPM = 3'd2;
  localparam logic [2:0] OP_DEPZ = 3'd3;
  localparam logic [2:0] OP_DEPI = 3'd4;
  localparam logic [2:0] OP_DESC = 3'd5;
endpackage

// File: rtl/bf_lowmask.sv
// Thermometer mask: bit i set when i < len. Lengths >= W give all ones.
module bf_lowmask #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic [LW-1:0] len,
  output logic [W-1:0]  mask
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask[i] = (len > LW'(i));
  end
endmodule

// File: rtl/bf_barrel.sv
// Logarithmic shifter, one stage per amount bit; LEFT picks the direction.
module bf_barrel #(
  parameter int W    = 32,
  parameter int SW   = 5,
  parameter bit LEFT = 1'b0
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [SW+1];
  assign stg[0] = din;
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    if (LEFT) begin : g_l
      assign stg[s+1] = amt[s] ? (stg[s] << SH) : stg[s];
    end else begin : g_r
      assign stg[s+1] = amt[s] ? (stg[s] >> SH) : stg[s];
    end
  end
  assign dout = stg[SW];
endmodule

// File: rtl/bf_unit.sv
module bf_unit
  import bf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int DIDX_W = 6,
  localparam int POS_W = $clog2(DATA_W),
  localparam int LEN_W = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              use_sar,
  input  logic [POS_W-1:0]  sar,
  input  logic [POS_W-1:0]  imm_pos,
  input  logic [LEN_W-1:0]  fld_len,
  input  logic [IMM_W-1:0]  imm_val,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam logic [DIDX_W-1:0] TOP_IDX  = DIDX_W'(DATA_W - 1);
  localparam logic [DIDX_W-1:0] WIDTH_IX = DIDX_W'(DATA_W);
  localparam logic [LEN_W-1:0]  FULL_LEN = LEN_W'(DATA_W);

  // ---------------- bound selection ----------------
  logic [POS_W-1:0]  pos_sel, ext_pos;
  logic [DIDX_W-1:0] desc_hi, desc_lo, hi_clip, desc_span;
  logic              desc_empty, is_desc;
  logic [LEN_W-1:0]  room, ext_len;

  assign is_desc    = (op == OP_DESC);
  assign pos_sel    = use_sar ? sar : imm_pos;
  assign desc_hi    = opb[2*DIDX_W-1:DIDX_W];
  assign desc_lo    = opb[DIDX_W-1:0];
  assign desc_empty = (desc_lo > desc_hi) || (desc_lo >= WIDTH_IX);
  assign hi_clip    = (desc_hi > TOP_IDX) ? TOP_IDX : desc_hi;
  assign desc_span  = hi_clip - desc_lo + DIDX_W'(1);
  assign ext_pos    = is_desc ? desc_lo[POS_W-1:0] : pos_sel;
  assign room       = FULL_LEN - LEN_W'(ext_pos);

  always_comb begin
    if (is_desc)
      ext_len = desc_empty ? '0 : LEN_W'(desc_span);
    else
      ext_len = (fld_len < room) ? fld_len : room;
  end

  // ---------------- extract path ----------------
  logic [DATA_W-1:0] ext_sh, ext_mask, ext_field, ext_res;
  logic              ext_sign;

  bf_barrel #(.W(DATA_W), .SW(POS_W), .LEFT(1'b0)) u_ext_shr (
    .din(opa), .amt(ext_pos), .dout(ext_sh)
  );
  bf_lowmask #(.W(DATA_W), .LW(LEN_W)) u_ext_mask (
    .len(ext_len), .mask(ext_mask)
  );

  assign ext_field = ext_sh & ext_mask;
  // top field bit: the only mask bit whose upper neighbour is clear
  assign ext_sign  = |(ext_sh & ext_mask & ~(ext_mask >> 1));
  assign ext_res   = ext_field |
                     (((op == OP_EXTS) && ext_sign) ? ~ext_mask : '0);

  // ---------------- deposit path ----------------
  logic [DATA_W-1:0] dep_src, dep_lmask, dep_mask, dep_sh, dep_base, dep_res;

  assign dep_src  = (op == OP_DEPI) ?
                    {{(DATA_W-IMM_W){imm_val[IMM_W-1]}}, imm_val} : opa;
  assign dep_base = (op == OP_DEPZ) ? '0 : opb;

  bf_lowmask #(.W(DATA_W), .LW(LEN_W)) u_dep_lmask (
    .len(fld_len), .mask(dep_lmask)
  );
  bf_barrel #(.W(DATA_W), .SW(POS_W), .LEFT(1'b1)) u_dep_mshl (
    .din(dep_lmask), .amt(pos_sel), .dout(dep_mask)
  );
  bf_barrel #(.W(DATA_W), .SW(POS_W), .LEFT(1'b1)) u_dep_dshl (
    .din(dep_src), .amt(pos_sel), .dout(dep_sh)
  );

  assign dep_res = (dep_base & ~dep_mask) | (dep_sh & dep_mask);

  // ---------------- result select ----------------
  logic [DATA_W-1:0] nxt_data;

  always_comb begin
    unique case (op)
      OP_EXTU, OP_EXTS:          nxt_data = ext_res;
      OP_DESC:                   nxt_data = ext_field;
      OP_DEPM, OP_DEPZ, OP_DEPI: nxt_data = dep_res;
      default:                   nxt_data = '0;
    endcase
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= nxt_data;
    end
  end
endmodule

// File: rtl/bf_unit_chk.sv
module bf_unit_chk
  import bf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int DIDX_W = 6,
  parameter int POS_W  = 5,
  parameter int LEN_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [DATA_W-1:0] opb,
  input logic [LEN_W-1:0]  fld_len,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R11
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data)); // R11
  AST_EXTU_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_EXTU && fld_len < LEN_W'(DATA_W))
    |=> !res_data[DATA_W-1]); // R1
  AST_EXTS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_EXTS && fld_len == LEN_W'(1))
    |=> (res_data == '0 || res_data == '1)); // R2
  AST_DEPM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_DEPM && fld_len == '0)
    |=> res_data == $past(opb)); // R9
  AST_DESC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_DESC && opb[DIDX_W-1:0] > opb[2*DIDX_W-1:DIDX_W])
    |=> res_data == '0); // R8
  AST_SPARE_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > OP_DESC) |=> res_data == '0); // R10
endmodule

bind bf_unit bf_unit_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .DIDX_W(DIDX_W),
  .POS_W(POS_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opb(opb),
  .fld_len(fld_len), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/bf_unit_bench.sv
`timescale 1ns/1ps
module bf_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        use_sar = 1'b0;
  logic [4:0]  sar = '0, imm_pos = '0;
  logic [5:0]  fld_len = '0;
  logic [4:0]  imm_val = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bf_unit u_bf_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa),
    .opb(opb), .use_sar(use_sar), .sar(sar), .imm_pos(imm_pos),
    .fld_len(fld_len), .imm_val(imm_val), .res_valid(res_valid),
    .res_data(res_data)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (op=%0d opa=%h opb=%h pos=%0d len=%0d)",
               tag, act, exp, op, opa, opb, use_sar ? sar : imm_pos, fld_len);
    end
  endtask

  // Bit-by-bit model of every opcode.
  function automatic logic [31:0] model(input int o, input logic [31:0] a,
      input logic [31:0] b, input int p, input int l, input logic [4:0] iv);
    logic [31:0] r, v;
    int n, hi, lo;
    r = '0;
    if (o == 0 || o == 1) begin
      n = 0;
      for (int i = 0; i < 32; i++)
        if (i < l && p + i < 32) begin r[i] = a[p+i]; n = i + 1; end
      if (o == 1 && n > 0)
        for (int i = n; i < 32; i++) r[i] = r[n-1];
    end else if (o >= 2 && o <= 4) begin
      r = (o == 3) ? 32'd0 : b;
      v = (o == 4) ? {{27{iv[4]}}, iv} : a;
      for (int i = 0; i < 32; i++)
        if (i < l && p + i < 32) r[p+i] = v[i];
    end else if (o == 5) begin
      hi = int'(b[11:6]);
      lo = int'(b[5:0]);
      for (int i = 0; i < 32; i++)
        if (i >= lo && i <= hi) r[i-lo] = a[i];
    end
    return r;
  endfunction

  function automatic string tag_of(input int o, input int p, input int l,
                                   input logic [31:0] b);
    if (o == 5) return (b[5:0] > b[11:6] || b[5:0] > 31) ? "R8" : "R7";
    if (o > 5) return "R10";
    if (l == 0) return "R9";
    if (p + l > 32) return "R3";
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_one(input int o, input int p, input int l,
                         input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    op       = 3'(o);
    opa      = a;
    opb      = b;
    use_sar  = 1'($urandom);
    sar      = use_sar ? 5'(p) : 5'($urandom);
    imm_pos  = use_sar ? 5'($urandom) : 5'(p);
    fld_len  = 6'(l);
    imm_val  = 5'($urandom);
    exp      = model(o, a, b, p, l, imm_val);
    @(posedge clk);
    #2;
    check("R11 valid", {31'd0, res_valid}, 32'd1);
    check(tag_of(o, p, l, b), res_data, exp);
  endtask

  task automatic idle_check();
    logic [31:0] prev;
    @(negedge clk);
    prev = res_data;
    in_valid = 1'b0;
    opa = $urandom;
    opb = $urandom;
    op  = 3'd3;
    @(posedge clk);
    #2;
    check("R11 idle valid", {31'd0, res_valid}, 32'd0);
    check("R11 idle hold", res_data, prev);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R12 reset valid", {31'd0, res_valid}, 32'd0);
    check("R12 reset data", res_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // All opcodes, all positions, lengths 0..33, random operands (R1-R6, R9, R10 and R3 clipping)
    for (int o = 0; o < 8; o++) begin
      for (int p = 0; p < 32; p++)
        for (int l = 0; l < 34; l++)
          run_one(o, p, l, $urandom, $urandom);
      idle_check();
    end

    // Descriptor bounds swept across empty, normal and clipped cases (R7, R8)
    for (int hi = 0; hi < 41; hi++)
      for (int lo = 0; lo < 41; lo++)
        run_one(5, 0, 0, $urandom, {$urandom} & 32'hFFFF_F000 |
                32'(hi) << 6 | 32'(lo));

    // Sign fill with all-ones and all-zeros sources (R2)
    for (int p = 0; p < 32; p++) begin
      run_one(1, p, 4, 32'hFFFF_FFFF, 32'd0);
      run_one(1, p, 4, 32'h0000_0000, 32'd0);
    end
    idle_check();

    done = 1'b1;
    finish_run();
  end
endmodule